// File: doc/BRIEF.md
# Passive Parallel Configuration Host Controller

This controller sits on the host side of a programmable logic device and loads it over a byte-wide passive parallel link. It accepts configuration bytes from a valid/ready stream. It drives an active-low configuration request line, a data clock and an 8-bit data bus. It watches two lines from the target: an open-drain active-low status line and a configuration-done line.

A run begins with a `start` pulse while the controller is idle. The controller pulls the request line low for a fixed number of cycles and then releases it. It waits, with a bounded cycle count, for the status line to read high. It then clocks the bytes out one at a time. Once the byte marked last has gone out, it keeps the data clock toggling until the done line rises, and then adds a fixed burst of initialization clocks. The run ends with exactly one of three outcomes: success, status error or timeout. That flag stays set until the next run starts.

Top module: `ppcfg_host`

## Requirements
- R1: After a synchronous reset, and whenever the controller is idle, `cfg_req_n` is 1, `dclk` is 0, `dbus` is 0x00 and `in_ready` is 0. Reset also clears `ok`, `err_status` and `err_timeout`.
- R2: A `start` sampled high in idle drives `cfg_req_n` low for exactly PULSE_CYC consecutive cycles. It is then released high, and it stays high for the rest of the run.
- R3: While `cfg_req_n` is low, or while the status input is low before the transfer begins, no byte is accepted and `dclk` stays 0. If the status input has not been seen high within STAT_WAIT cycles after release, `err_status` is set and the controller returns to idle.
- R4: `in_ready` is high only while the controller waits for a byte, the status input is high and `dclk` is low. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- R5: Each accepted byte is placed on `dbus` for one setup cycle. `dclk` is then high for one cycle and low for one cycle, and only after that is the next byte taken. The bytes appear in stream order, with exactly one rising edge of `dclk` per byte.
- R6: If the status input reads low at any point after the transfer has begun, the controller stops clocking, sets `err_status` and returns to idle. When this happens in the same cycle as a byte offer, that byte is not accepted.
- R7: After the byte marked by `in_last`, `dclk` toggles every cycle until `done_i` is sampled high. It then runs 2·INIT_CLK further cycles that contain exactly INIT_CLK high phases of `dclk`, after which `ok` is set.
- R8: If `done_i` is not sampled high within DONE_LIMIT cycles of post-data clocking, `err_timeout` is set and the controller returns to idle.
- R9: At most one of `ok`, `err_status` and `err_timeout` is high at a time. Each flag holds until the next accepted `start`. A `start` given during a run is ignored and causes no second pulse on `cfg_req_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (taken in idle only) |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final byte of the bitstream |
| in_ready | output | 1 | Controller takes the byte this cycle |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| dclk | output | 1 | Data clock to the target |
| dbus | output | 8 | Configuration data bus |
| stat_n_i | input | 1 | Open-drain status line as read back (low = target in reset or error) |
| done_i | input | 1 | Configuration-done line from the target |
| busy | output | 1 | A run is in progress |
| ok | output | 1 | Last run finished successfully |
| err_status | output | 1 | Last run ended on a low status line |
| err_timeout | output | 1 | Last run ended waiting for done |

## Verification
The critical overlap is the status line dropping in the same cycle that the stream offers a byte. The abort must win, and the byte must neither be taken nor clocked. The bench provokes this by pulling the status line low at the moment it sees `in_ready` high with a byte pending. It then requires `err_status`, the number of `dclk` rising edges equal to the bytes accepted before the drop, and the outputs idle. A second overlap, a `start` arriving while a run is clocking, is judged by counting the falling edges of `cfg_req_n` in that run and by checking that the run still ends in success.

// File: rtl/ppcfg_host.sv
module ppcfg_host #(
  parameter int PULSE_CYC  = 8,
  parameter int STAT_WAIT  = 500,
  parameter int INIT_CLK   = 10,
  parameter int DONE_LIMIT = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_req_n,
  output logic       dclk,
  output logic [7:0] dbus,
  input  logic       stat_n_i,
  input  logic       done_i,
  output logic       busy,
  output logic       ok,
  output logic       err_status,
  output logic       err_timeout
);
  localparam int M1   = (PULSE_CYC > STAT_WAIT) ? PULSE_CYC : STAT_WAIT;
  localparam int M2   = (DONE_LIMIT > 2 * INIT_CLK) ? DONE_LIMIT : 2 * INIT_CLK;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PULSE, S_WAIT, S_FETCH, S_SETUP, S_HI, S_LO, S_FLUSH, S_INIT
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          tog, last_q;
  logic [7:0]    dq;

  wire in_cfg = (st == S_FETCH) || (st == S_SETUP) || (st == S_HI) ||
                (st == S_LO) || (st == S_FLUSH) || (st == S_INIT);

  assign busy      = (st != S_IDLE);
  assign cfg_req_n = (st != S_PULSE);
  assign in_ready  = (st == S_FETCH) && stat_n_i;
  assign dclk      = (st == S_HI) || (((st == S_FLUSH) || (st == S_INIT)) && tog);
  assign dbus      = busy ? dq : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      tog         <= 1'b0;
      last_q      <= 1'b0;
      dq          <= 8'h00;
      ok          <= 1'b0;
      err_status  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          tog <= 1'b0;
          if (start) begin
            ok          <= 1'b0;
            err_status  <= 1'b0;
            err_timeout <= 1'b0;
            dq          <= 8'h00;
            st          <= S_PULSE;
          end
        end
        S_PULSE:
          if (cnt == CW'(PULSE_CYC - 1)) begin
            cnt <= '0;
            st  <= S_WAIT;
          end
        S_WAIT:
          if (stat_n_i) begin
            cnt <= '0;
            st  <= S_FETCH;
          end else if (cnt == CW'(STAT_WAIT - 1)) begin
            err_status <= 1'b1;
            st         <= S_IDLE;
          end
        default:
          if (in_cfg && !stat_n_i) begin
            err_status <= 1'b1;
            tog        <= 1'b0;
            st         <= S_IDLE;
          end else begin
            case (st)
              S_FETCH:
                if (in_valid) begin
                  dq     <= in_data;
                  last_q <= in_last;
                  st     <= S_SETUP;
                end
              S_SETUP: st <= S_HI;
              S_HI:    st <= S_LO;
              S_LO: begin
                cnt <= '0;
                tog <= 1'b0;
                st  <= last_q ? S_FLUSH : S_FETCH;
              end
              S_FLUSH: begin
                tog <= ~tog;
                if (done_i) begin
                  cnt <= '0;
                  st  <= S_INIT;
                end else if (cnt == CW'(DONE_LIMIT - 1)) begin
                  err_timeout <= 1'b1;
                  tog         <= 1'b0;
                  st          <= S_IDLE;
                end
              end
              S_INIT: begin
                tog <= ~tog;
                if (cnt == CW'(2 * INIT_CLK - 1)) begin
                  ok  <= 1'b1;
                  tog <= 1'b0;
                  st  <= S_IDLE;
                end
              end
              default: st <= S_IDLE;
            endcase
          end
      endcase
    end
  end
endmodule

module ppcfg_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       cfg_req_n,
  input logic       dclk,
  input logic [7:0] dbus,
  input logic       stat_n_i,
  input logic       ok,
  input logic       err_status,
  input logic       err_timeout
);
  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (cfg_req_n && !dclk && dbus == 8'h00 && !in_ready));

  p_pulse_min_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_req_n) |=> !cfg_req_n);

  p_no_clk_in_reset_r3: assert property (@(posedge clk) disable iff (rst)
    dclk |-> cfg_req_n);

  p_ready_gated_r4: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!dclk && stat_n_i && cfg_req_n));

  p_setup_stable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk) |-> $stable(dbus));

  p_stop_on_status_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_n_i) |=> !dclk);

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok, err_status, err_timeout}));
endmodule

bind ppcfg_host ppcfg_host_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .cfg_req_n(cfg_req_n),
  .dclk(dclk), .dbus(dbus), .stat_n_i(stat_n_i), .ok(ok),
  .err_status(err_status), .err_timeout(err_timeout)
);

// File: tb/ppcfg_host_bench.sv
module ppcfg_host_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC  = 4;
  localparam int STAT_WAIT  = 20;
  localparam int INIT_CLK   = 3;
  localparam int DONE_LIMIT = 16;
  localparam int NV = 6;
  // nbytes, status delay, extra done edges, kill after edge, outcome(0 ok,1 status,2 timeout), expected accepted
  localparam int TV[NV][6] = '{
    '{4, 3, 2, 0, 0, 4},
    '{1, 0, 1, 0, 0, 1},
    '{6, 10, 3, 0, 0, 6},
    '{3, 40, 2, 0, 1, 0},
    '{5, 2, 30, 0, 2, 5},
    '{8, 5, 2, 3, 1, 3}
  };

  logic clk = 0, rst = 1, start = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, in_last = 0;
  logic in_ready, cfg_req_n, dclk, busy, ok, err_status, err_timeout;
  logic [7:0] dbus;
  logic stat_n, done_q, hi_ok, kill_m, kill_now, clr;

  int errors = 0, checks = 0;
  int stat_dly = 0, done_at = 1000, kill_after = 0;
  int hi_cnt, edges, low_cyc, req_falls, ncap, init_hi, viol_rdy, viol_setup, nacc;
  logic [7:0] caps [32];
  logic prev_dclk, prev_req, done_prev;
  logic [7:0] prev_dbus;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign stat_n = cfg_req_n && hi_ok && !kill_m && !kill_now;

  ppcfg_host #(.PULSE_CYC(PULSE_CYC), .STAT_WAIT(STAT_WAIT), .INIT_CLK(INIT_CLK),
               .DONE_LIMIT(DONE_LIMIT)) u_ppcfg_host (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cfg_req_n(cfg_req_n), .dclk(dclk),
    .dbus(dbus), .stat_n_i(stat_n), .done_i(done_q), .busy(busy), .ok(ok),
    .err_status(err_status), .err_timeout(err_timeout));

  initial begin
    hi_ok = 0; kill_m = 0; done_q = 0; clr = 0; kill_now = 0;
    hi_cnt = 0; edges = 0; low_cyc = 0; req_falls = 0; ncap = 0; init_hi = 0;
    viol_rdy = 0; viol_setup = 0; prev_dclk = 0; prev_req = 1; done_prev = 0; prev_dbus = 0;
  end

  // target model and port monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (clr) begin
      kill_m = 0; done_q = 0; edges = 0; low_cyc = 0; req_falls = 0; ncap = 0;
      init_hi = 0; done_prev = 0;
    end else begin
      done_prev = done_q;
      if (in_ready && (dclk || !stat_n)) viol_rdy++;
      if (!cfg_req_n) begin
        hi_cnt = 0; edges = 0; done_q = 0; low_cyc++;
      end else hi_cnt++;
      if (prev_req && !cfg_req_n) req_falls++;
      if (dclk && !prev_dclk) begin
        if (dbus != prev_dbus) viol_setup++;
        if (ncap < 32) caps[ncap] = dbus;
        ncap++;
        edges++;
        if (edges >= done_at) done_q = 1;
        if (kill_after != 0 && edges == kill_after) kill_m = 1;
      end
      if (done_prev && !ok && dclk) init_hi++;
    end
    hi_ok = (hi_cnt > stat_dly);
    prev_dclk = dclk; prev_req = cfg_req_n; prev_dbus = dbus;
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'(v * 37 + i * 13 + 5);
  endfunction

  task automatic run(input int v, input int nb, input int sd, input int ex, input int ka,
                     input int glitch, input int okill, output int got);
    int lim;
    bit stop;
    stat_dly = sd; done_at = nb + ex; kill_after = ka; nacc = 0;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; start = 1;
    @(negedge clk); start = 0;
    stop = 0;
    for (int i = 0; i < nb && !stop; i++) begin
      if (i == glitch) begin start = 1; @(negedge clk); start = 0; end
      in_data = pat(v, i); in_last = (i == nb - 1); in_valid = 1;
      lim = 0;
      while (1) begin
        if (err_status || err_timeout || lim > 500) begin stop = 1; break; end
        if (in_ready) begin
          if (i == okill) begin kill_now = 1; stop = 1; break; end
          @(posedge clk); nacc++;
          @(negedge clk);
          break;
        end
        @(negedge clk); lim++;
      end
    end
    lim = 0;
    while (!(ok || err_status || err_timeout) && lim < 2000) begin @(negedge clk); lim++; end
    in_valid = 0; in_last = 0; kill_now = 0;
    got = ok ? 0 : err_status ? 1 : err_timeout ? 2 : 3;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic idle_chk(input string tag);
    chk(cfg_req_n == 1 && dclk == 0 && dbus == 0 && in_ready == 0, tag,
        {cfg_req_n, dclk, in_ready, dbus}, 11'h400);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    idle_chk("R1 reset outputs");
    chk(!ok && !err_status && !err_timeout, "R1 reset flags", {ok, err_status, err_timeout}, 0);

    for (int v = 0; v < NV; v++) begin
      run(v, TV[v][0], TV[v][1], TV[v][2], TV[v][3], -1, -1, got);
      chk(got == TV[v][4], "R3/R6/R7/R8 outcome", got, TV[v][4]);
      chk(low_cyc == PULSE_CYC, "R2 request pulse width", low_cyc, PULSE_CYC);
      chk(req_falls == 1, "R2 single pulse", req_falls, 1);
      chk(nacc == TV[v][5], "R4 bytes accepted", nacc, TV[v][5]);
      for (int i = 0; i < nacc; i++)
        chk(caps[i] == pat(v, i), "R5 byte order", caps[i], pat(v, i));
      if (TV[v][4] == 0) begin
        chk(ncap >= TV[v][0] + TV[v][2], "R7 flush edges", ncap, TV[v][0] + TV[v][2]);
        chk(init_hi == INIT_CLK, "R7 init clocks", init_hi, INIT_CLK);
      end
      if (TV[v][4] == 1)
        chk(ncap == TV[v][5], "R6 no clock after abort", ncap, TV[v][5]);
      idle_chk("R1 idle after run");
    end

    // R6: status drops in the same cycle as a byte offer
    run(7, 5, 2, 2, 0, -1, 2, got);
    chk(got == 1, "R6 abort on offer", got, 1);
    chk(nacc == 2, "R6 offered byte not taken", nacc, 2);
    chk(ncap == 2, "R6 edges equal accepted", ncap, 2);
    idle_chk("R1 idle after abort");

    // R9: flag held, cleared by next start; start ignored mid-run
    repeat (10) @(negedge clk);
    chk(err_status == 1 && ok == 0, "R9 flag sticky", err_status, 1);
    run(8, 3, 3, 2, 0, 1, -1, got);
    chk(got == 0, "R9 run ok after glitch start", got, 0);
    chk(req_falls == 1, "R9 mid-run start ignored", req_falls, 1);
    chk(err_status == 0, "R9 old flag cleared", err_status, 0);
    for (int i = 0; i < 3; i++)
      chk(caps[i] == pat(8, i), "R5 byte order after glitch", caps[i], pat(8, i));

    // R1: reset during clocking
    stat_dly = 1; done_at = 1000; kill_after = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    in_valid = 1; in_data = 8'hA5; in_last = 0;
    repeat (12) @(negedge clk);
    chk(busy == 1, "R1 busy before reset", busy, 1);
    rst = 1; @(negedge clk); rst = 0; in_valid = 0;
    idle_chk("R1 idle after mid-run reset");
    chk(!busy && !ok && !err_status && !err_timeout, "R1 flags after mid-run reset",
        {busy, ok, err_status, err_timeout}, 0);

    chk(viol_rdy == 0, "R4 ready only with status high and clock low", viol_rdy, 0);
    chk(viol_setup == 0, "R5 setup cycle before rising clock", viol_setup, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule